// File: doc/BRIEF.md
# Frame Sync Pulse Generator

This block divides a sync clock down to two frame-rate outputs: a fast 8 kHz sync and a slow 2 kHz sync whose period is a whole number of fast periods. Each output rises at the start of its own period. Every slow rise lands on a fast rise, so the two outputs stay phase locked to each other.

Each output has its own shape selection. It is either a 50% duty-cycle square wave or a narrow pulse whose high time is a count of sync-clock periods. A single width register sets that count for both outputs. A two-entry write port loads the shape register and the width register. A new setting is held back until the affected output starts its next period, so a write never truncates or stretches a pulse already in progress.

With the default parameters and a 19.44 MHz sync clock, the fast period is 2430 cycles and the slow period is 9720 cycles. A width of 4 then gives a pulse of about 206 ns.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both outputs are low after that edge. Reset returns the shape field to 00 and the width to 1.
- R2: The fast output has a period of FAST_PERIOD cycles. The slow output has a period of FAST_PERIOD*RATIO cycles. Every rise of the slow output happens on the same edge as a rise of the fast output.
- R3: An output in square-wave shape is high for the first FAST_PERIOD/2 (fast) or FAST_PERIOD*RATIO/2 (slow) cycles of its period and low for the rest.
- R4: The shape field is written at `wr_addr`=0 from `wr_data[5:4]`. Bit 4 set selects narrow-pulse shape for the fast output. Bit 5 set selects narrow-pulse shape for the slow output. All other data bits have no effect.
- R5: An output in narrow-pulse shape is high for exactly W cycles at the start of each period, where W is the width register.
- R6: The width register is written at `wr_addr`=1 from `wr_data[3:0]`, and the upper data bits are ignored. A width of 0 behaves as a width of 1.
- R7: The same width register sets the pulse length of both outputs when both are in narrow-pulse shape.
- R8: A write to either register changes an output only from the first cycle of that output's next period.
- R9: The first period of both outputs begins at the first clock edge with `rst_n` high, so both outputs are high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the shape register, 1 selects the width register |
| wr_data | input | 8 | Write data |
| sync_fast_o | output | 1 | Fast (8 kHz) frame sync |
| sync_slow_o | output | 1 | Slow (2 kHz) frame sync, aligned to every RATIO-th fast period |

## Verification
The bench builds the block with FAST_PERIOD=20 and RATIO=4, so the slow period is 80 cycles. At that size it can cover every combination of the four shape codes and all sixteen width codes, including 0 and 15. It checks every cycle of both outputs against an arithmetic model of the phase counters. Writes land at scattered phases within the periods, which exercises the deferred-update rule, and a reset in the middle of a run confirms that the first period starts again cleanly.

// File: rtl/fsg_pkg.sv
// Shared constants and types for the frame sync generator.
// Assumes a 1-bit register address and an 8-bit write data bus.
package fsg_pkg;
    localparam int  WIDTH_BITS = 4;
    localparam int  MODE_LSB   = 4;
    localparam logic ADDR_SHAPE = 1'b0;
    localparam logic ADDR_WIDTH = 1'b1;

    typedef logic [WIDTH_BITS-1:0] width_t;

    // Shape selection: slow_var is written from bit MODE_LSB+1, fast_var from bit MODE_LSB.
    typedef struct packed {
        logic slow_var;
        logic fast_var;
    } shape_t;
endpackage

// File: rtl/fsg_regs.sv
// Configuration registers: shape field and pulse width.
// Assumes the writer holds wr_addr/wr_data valid with wr_en for one cycle.
module fsg_regs
    import fsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output shape_t     shape_o,
    output width_t     width_o
);
    // Load the addressed register; reset restores square waves and width 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shape_o <= '0;
            width_o <= width_t'(1);
        end else if (wr_en) begin
            if (wr_addr == ADDR_SHAPE)
                shape_o <= shape_t'(wr_data[MODE_LSB+1:MODE_LSB]);
            else
                width_o <= wr_data[WIDTH_BITS-1:0];
        end
    end
endmodule

// File: rtl/fsg_divider.sv
// Two free-running phase counters: one over the fast period, one over the slow period.
// Assumes the slow period is an integer multiple (RATIO) of the fast period.
module fsg_divider #(
    parameter int FAST_PERIOD = 2430,
    parameter int RATIO       = 4,
    parameter int PW          = $clog2(FAST_PERIOD*RATIO)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] fast_pos_o,
    output logic [PW-1:0] slow_pos_o,
    output logic          fast_start_o,
    output logic          slow_start_o
);
    localparam int SLOW_PERIOD = FAST_PERIOD * RATIO;

    // Fast phase counter, wraps every FAST_PERIOD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                                fast_pos_o <= '0;
        else if (fast_pos_o == PW'(FAST_PERIOD-1)) fast_pos_o <= '0;
        else                                       fast_pos_o <= fast_pos_o + 1'b1;
    end

    // Slow phase counter, wraps every SLOW_PERIOD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                                slow_pos_o <= '0;
        else if (slow_pos_o == PW'(SLOW_PERIOD-1)) slow_pos_o <= '0;
        else                                       slow_pos_o <= slow_pos_o + 1'b1;
    end

    // Period start flags for the shapers.
    always_comb begin
        fast_start_o = (fast_pos_o == '0);
        slow_start_o = (slow_pos_o == '0);
    end

    // Slow period start must coincide with a fast period start.
    assert_slow_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slow_start_o |-> fast_start_o);

    // Both counters stay inside their periods.
    assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_pos_o < PW'(FAST_PERIOD)) && (slow_pos_o < PW'(SLOW_PERIOD)));
endmodule

// File: rtl/fsg_shaper.sv
// Turns a phase count into one sync output: square wave or narrow pulse.
// Assumes pos counts 0..PERIOD-1 and start is high exactly when pos is 0.
// Shape and width are captured at period start so a period is never cut short.
module fsg_shaper
    import fsg_pkg::*;
#(
    parameter int PERIOD = 2430,
    parameter int PW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pos_i,
    input  logic          start_i,
    input  logic          var_req_i,
    input  width_t        width_req_i,
    output logic          pulse_o
);
    localparam int LW = (PW > WIDTH_BITS) ? PW : WIDTH_BITS;

    logic   act_var;
    width_t act_w;
    logic   eff_var;
    width_t eff_w;
    logic [LW-1:0] high_len;

    // Pick the requested setting at period start, otherwise the captured one.
    always_comb begin
        eff_var = start_i ? var_req_i   : act_var;
        eff_w   = start_i ? width_req_i : act_w;
        if (eff_w == '0) eff_w = width_t'(1);
        high_len = eff_var ? LW'(eff_w) : LW'(PERIOD / 2);
    end

    // Capture the setting used for the rest of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_var <= 1'b0;
            act_w   <= width_t'(1);
        end else if (start_i) begin
            act_var <= var_req_i;
            act_w   <= width_req_i;
        end
    end

    // Registered output: high while the phase is below the high length.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= (LW'(pos_i) < high_len);
    end

    // Captured setting may only change at a period start.
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(act_var) && $stable(act_w)));

    // The output only rises on the edge that starts a period.
    assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(start_i));
endmodule

// File: rtl/frame_sync_gen.sv
// Frame sync generator top: registers, divider and one shaper per output.
// Assumes FAST_PERIOD is at least 2 and larger than the widest pulse (15).
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int FAST_PERIOD = 2430,
    parameter int RATIO       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output logic       sync_fast_o,
    output logic       sync_slow_o
);
    localparam int SLOW_PERIOD = FAST_PERIOD * RATIO;
    localparam int PW          = $clog2(SLOW_PERIOD);

    shape_t        shape;
    width_t        width;
    logic [PW-1:0] pos_a   [2];
    logic          start_a [2];
    logic          var_a   [2];
    logic          pulse_a [2];

    fsg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .shape_o (shape),
        .width_o (width)
    );

    fsg_divider #(.FAST_PERIOD(FAST_PERIOD), .RATIO(RATIO), .PW(PW)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .fast_pos_o   (pos_a[0]),
        .slow_pos_o   (pos_a[1]),
        .fast_start_o (start_a[0]),
        .slow_start_o (start_a[1])
    );

    // Route the shape bit belonging to each output.
    always_comb begin
        var_a[0] = shape.fast_var;
        var_a[1] = shape.slow_var;
    end

    // One shaper per output; index 0 is fast, index 1 is slow.
    for (genvar i = 0; i < 2; i++) begin : g_out
        localparam int PER = (i == 0) ? FAST_PERIOD : SLOW_PERIOD;
        fsg_shaper #(.PERIOD(PER), .PW(PW)) u_shp (
            .clk         (clk),
            .rst_n       (rst_n),
            .pos_i       (pos_a[i]),
            .start_i     (start_a[i]),
            .var_req_i   (var_a[i]),
            .width_req_i (width),
            .pulse_o     (pulse_a[i])
        );
    end

    // Drive the output ports.
    always_comb begin
        sync_fast_o = pulse_a[0];
        sync_slow_o = pulse_a[1];
    end

    // Reset forces both outputs low on the following cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!sync_fast_o && !sync_slow_o));

    // A slow rise is always accompanied by the fast output being high.
    assert_phase_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_slow_o) |-> sync_fast_o);
endmodule

// File: tb/sim_frame_sync_gen.sv
// Near-exhaustive sweep of shapes and widths at a small period, with an arithmetic model.
module sim_frame_sync_gen;
    localparam int FP = 20;
    localparam int RT = 4;
    localparam int SP = FP * RT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sync_fast_o;
    logic       sync_slow_o;

    int errors = 0;
    int checks = 0;

    // Model state
    int k = 0;
    logic m_fv = 0, m_sv = 0;
    logic [3:0] m_w = 4'd1;
    logic a_fv = 0, a_sv = 0;
    logic [3:0] a_fw = 4'd1, a_sw = 4'd1;

    frame_sync_gen #(.FAST_PERIOD(FP), .RATIO(RT)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_fast_o(sync_fast_o), .sync_slow_o(sync_slow_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at k=%0d: actual=%0b expected=%0b", req, k, act, exp);
        end
    endtask

    function automatic int eff(input logic [3:0] w);
        return (w == 0) ? 1 : int'(w);
    endfunction

    function automatic string tag(input logic v, input logic [3:0] w, input bit slow,
                                  input bit pend);
        if (k == 1)   return "R9";
        if (pend)     return "R8";
        if (v && w == 0) return "R6";
        if (v && slow) return "R7";
        if (v)        return "R5";
        if (m_fv || m_sv) return "R4";
        return "R3";
    endfunction

    // One clock with optional write; called away from the edge, samples 2 ns after it.
    task automatic step(input logic we, input logic adr, input logic [7:0] d);
        int pf, ps, lf, ls;
        bit pendf, pends;
        wr_en = we; wr_addr = adr; wr_data = d;
        @(posedge clk);
        #2;
        k++;
        pf = (k - 1) % FP;
        ps = (k - 1) % SP;
        if (pf == 0) begin a_fv = m_fv; a_fw = m_w; end
        if (ps == 0) begin a_sv = m_sv; a_sw = m_w; end
        lf = a_fv ? eff(a_fw) : FP / 2;
        ls = a_sv ? eff(a_sw) : SP / 2;
        pendf = (m_fv != a_fv) || (a_fv && m_w != a_fw);
        pends = (m_sv != a_sv) || (a_sv && m_w != a_sw);
        check(tag(a_fv, a_fw, 0, pendf), sync_fast_o, pf < lf);
        check(tag(a_sv, a_sw, 1, pends), sync_slow_o, ps < ls);
        if (ps == 0) check("R2", sync_fast_o, 1'b1);
        if (we) begin
            if (adr == 1'b0) begin m_fv = d[4]; m_sv = d[5]; end
            else m_w = d[3:0];
        end
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R1", sync_fast_o, 1'b0);
        check("R1", sync_slow_o, 1'b0);
        k = 0;
        m_fv = 0; m_sv = 0; m_w = 4'd1;
        a_fv = 0; a_sv = 0; a_fw = 4'd1; a_sw = 4'd1;
        rst_n = 1'b1;
    endtask

    initial begin
        #2;
        do_reset();
        // Default square waves across two slow periods (R3, R9).
        repeat (2 * SP) step(1'b0, 1'b0, 8'h00);
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 16; w++) begin
                logic [1:0] mm;
                logic [3:0] ww;
                mm = m[1:0];
                ww = w[3:0];
                if (m == 2 && w == 0) begin
                    // Reset mid-run restores defaults (R1).
                    do_reset();
                    repeat (FP + 3) step(1'b0, 1'b0, 8'h00);
                end
                // Garbage in unused bits must be ignored (R4, R6).
                step(1'b1, 1'b0, {2'b11, mm, 4'h5});
                repeat ((w * 7) % 13) step(1'b0, 1'b0, 8'h00);
                step(1'b1, 1'b1, {4'h9, ww});
                repeat (SP + (w * 11) % 23) step(1'b0, 1'b0, 8'h00);
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule